// File: doc/BRIEF.md
# Two-Lane Block Exchange Shuffler

This block sits between two stages of a streaming feedforward FFT that carries two complex samples per clock. The data arrive in frames of 2L cycles. The upper lane carries block A and then block B, and the lower lane carries block C and then block D, where each block is L samples long. The block reorders them so that A and B leave together on the two lanes, and C and D follow together. In effect, the second upper block and the first lower block change places. The block does no arithmetic. It is built only from two L-deep delay lines and a pair of 2:1 multiplexers.

A small control machine sets the multiplexer select. It has three states:
- `ST_IDLE`: entered at reset, with the select held at 0.
- `ST_PASS`: select 0. Upper input goes into the output delay, and the lower lane output takes the delayed lower input.
- `ST_SWAP`: select 1. The delayed lower input goes into the output delay, and the lower lane output takes the live upper input.

It has four transitions:
- `IDLE->PASS`: on a frame start.
- `PASS->SWAP`: after L cycles.
- `SWAP->PASS`: after L cycles.
- `ANY->PASS`: a frame start, even in the middle of a frame, puts the machine in `ST_PASS` with the count at zero in that same cycle.

Once started, the machine runs on its own. A pair is accepted every cycle and nothing stalls. The valid flag does not gate the data path; it is only delayed to line up with the data. The upper output is registered. The lower output is a multiplexer on the delayed lower lane or on the live upper lane.

Top module: `lane_shuffler`

## Requirements
- R1: After reset, `out_valid` is 0 and all four output data words are 0 until input data reach them.
- R2: In a cycle where the control is in `ST_SWAP`, the upper output pair equals the upper input from L cycles earlier, and the lower output equals the present upper input (A[j] next to B[j]).
- R3: In a cycle where the control is in `ST_PASS` after a frame start, and the cycle L earlier was in `ST_SWAP`, the upper output equals the lower input from 2L cycles earlier, and the lower output equals the lower input from L cycles earlier (C[j] next to D[j]).
- R4: `out_valid` equals `in_valid` from exactly L cycles earlier. `in_valid` has no effect on the data path or on the phase sequence.
- R5: After a frame start, `ST_PASS` and `ST_SWAP` alternate every L cycles without end, so back-to-back frames stream with no gap.
- R6: `in_start` high puts the control into `ST_PASS` with the phase count at zero in that same cycle, whatever the current state or count.
- R7: Before the first `in_start` the select stays 0, so each lane passes straight through with a delay of L cycles.
- R8: Each output word is the real part in the upper DW bits and the imaginary part in the lower DW bits of the source sample, and the two parts always move as one unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pair valid, delayed to out_valid |
| in_start | input | 1 | Marks the first cycle of a 2L-cycle frame |
| up_re | input | DW | Upper lane input, real part |
| up_im | input | DW | Upper lane input, imaginary part |
| lo_re | input | DW | Lower lane input, real part |
| lo_im | input | DW | Lower lane input, imaginary part |
| out_valid | output | 1 | Output pair valid |
| out_up_re | output | DW | Upper lane output, real part |
| out_up_im | output | DW | Upper lane output, imaginary part |
| out_lo_re | output | DW | Lower lane output, real part |
| out_lo_im | output | DW | Lower lane output, imaginary part |

## Verification
The bench builds three copies with block lengths 4, 1 and 2, drives them with the same labelled ramp, and checks every output cycle against a cycle model of each copy.
- L = 1 reaches the degenerate case: one-cycle phases, a one-bit counter that never counts, and single-register delays.
- L = 2 and L = 4 reach multi-cycle phases, where a restart can land on any count in either phase.
- The same stream also covers the period before the first start, valid gaps, and restarts at offsets that fall in different phases for each length.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

    // Control phases of the exchange network
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_SWAP = 2'd2
    } shuf_state_t;

    // Width of a phase counter able to hold len-1 (at least one bit)
    function automatic int cnt_bits(input int len);
        return (len > 1) ? $clog2(len) : 1;
    endfunction

endpackage

// File: rtl/shuf_delay.sv
module shuf_delay #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                stg[i] <= '0;
            end
        end else begin
            stg[0] <= d;
            for (int i = 1; i < DEPTH; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[DEPTH-1];

endmodule

// File: rtl/shuf_ctrl.sv
module shuf_ctrl
    import shuf_pkg::*;
#(
    parameter int BLK_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic sel
);

    localparam int            CW        = cnt_bits(BLK_LEN);
    localparam logic [CW-1:0] LAST      = CW'(BLK_LEN - 1);
    localparam logic          SEL_AFTER = (BLK_LEN == 1);
    localparam int            RW        = CW + 2;

    shuf_state_t   cur_st, eff_st, nxt_st;
    logic [CW-1:0] cnt_q, eff_cnt, nxt_cnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_st <= ST_IDLE;
            cnt_q  <= '0;
        end else begin
            cur_st <= nxt_st;
            cnt_q  <= nxt_cnt;
        end
    end

    // Next-state logic; a start overrides the registered phase in its own cycle
    always_comb begin
        eff_st  = start ? ST_PASS : cur_st;
        eff_cnt = start ? '0 : cnt_q;
        nxt_st  = eff_st;
        nxt_cnt = eff_cnt;
        unique case (eff_st)
            ST_IDLE: begin
                nxt_st  = ST_IDLE;
                nxt_cnt = '0;
            end
            ST_PASS: begin
                if (eff_cnt == LAST) begin
                    nxt_st  = ST_SWAP;
                    nxt_cnt = '0;
                end else begin
                    nxt_cnt = eff_cnt + CW'(1);
                end
            end
            ST_SWAP: begin
                if (eff_cnt == LAST) begin
                    nxt_st  = ST_PASS;
                    nxt_cnt = '0;
                end else begin
                    nxt_cnt = eff_cnt + CW'(1);
                end
            end
            default: begin
                nxt_st  = ST_IDLE;
                nxt_cnt = '0;
            end
        endcase
    end

    // Output logic
    always_comb begin
        sel = (eff_st == ST_SWAP);
    end

    // Checking logic: run length of the current select value
    logic          sel_q;
    logic [RW-1:0] run_q, run_now;

    always_comb begin
        if (eff_st == ST_IDLE)              run_now = '0;
        else if (start || (sel != sel_q))   run_now = RW'(1);
        else                                run_now = run_q + RW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
            run_q <= '0;
        end else begin
            sel_q <= sel;
            run_q <= run_now;
        end
    end

    // R5: a phase never lasts longer than L cycles
    assert_phase_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_now <= RW'(BLK_LEN));

    // R5: a full phase is followed by the other phase unless a start intervenes
    assert_phase_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_st != ST_IDLE && run_now == RW'(BLK_LEN)) |=> (start || sel != $past(sel)));

    // R6: one cycle after a start the sequence is at count one of the first phase
    assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (start || sel == SEL_AFTER));

endmodule

// File: rtl/shuf_xbar.sv
module shuf_xbar #(
    parameter int DW    = 12,
    parameter int PARTS = 2
) (
    input  logic                sel,
    input  logic [PARTS*DW-1:0] direct_in,
    input  logic [PARTS*DW-1:0] cross_in,
    output logic [PARTS*DW-1:0] to_delay,
    output logic [PARTS*DW-1:0] to_lane
);

    for (genvar g = 0; g < PARTS; g++) begin : g_part
        assign to_delay[g*DW +: DW] = sel ? cross_in[g*DW +: DW]  : direct_in[g*DW +: DW];
        assign to_lane[g*DW +: DW]  = sel ? direct_in[g*DW +: DW] : cross_in[g*DW +: DW];
    end

endmodule

// File: rtl/lane_shuffler.sv
module lane_shuffler #(
    parameter int BLK_LEN = 4,
    parameter int DW      = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_start,
    input  logic [DW-1:0] up_re,
    input  logic [DW-1:0] up_im,
    input  logic [DW-1:0] lo_re,
    input  logic [DW-1:0] lo_im,
    output logic          out_valid,
    output logic [DW-1:0] out_up_re,
    output logic [DW-1:0] out_up_im,
    output logic [DW-1:0] out_lo_re,
    output logic [DW-1:0] out_lo_im
);

    localparam int LW = 2 * DW;

    logic          sel_w;
    logic [LW-1:0] up_pk, lo_pk, lo_dly, to_odly, up_q, lo_mux;
    logic [0:0]    vld_q;

    assign up_pk = {up_re, up_im};
    assign lo_pk = {lo_re, lo_im};

    shuf_ctrl #(.BLK_LEN(BLK_LEN)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (in_start),
        .sel   (sel_w)
    );

    shuf_delay #(.DEPTH(BLK_LEN), .WIDTH(LW)) u_lo_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lo_pk),
        .q     (lo_dly)
    );

    shuf_xbar #(.DW(DW), .PARTS(2)) u_xbar (
        .sel       (sel_w),
        .direct_in (up_pk),
        .cross_in  (lo_dly),
        .to_delay  (to_odly),
        .to_lane   (lo_mux)
    );

    shuf_delay #(.DEPTH(BLK_LEN), .WIDTH(LW)) u_up_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (to_odly),
        .q     (up_q)
    );

    shuf_delay #(.DEPTH(BLK_LEN), .WIDTH(1)) u_vld_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (in_valid),
        .q     (vld_q)
    );

    assign {out_up_re, out_up_im} = up_q;
    assign {out_lo_re, out_lo_im} = lo_mux;
    assign out_valid              = vld_q[0];

    // Checking logic: cycles since reset, so that history windows are filled
    logic [5:0] warm_q;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                warm_q <= '0;
        else if (warm_q != 6'h3f)  warm_q <= warm_q + 6'd1;
    end

    assign warm = (warm_q > 6'(2 * BLK_LEN + 1));

    // R4: valid follows the input valid by exactly L cycles
    assert_valid_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, BLK_LEN)));

    // R2 / R7: a sample fed while the select was 0 leaves the upper lane L cycles later
    assert_upper_direct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(sel_w, BLK_LEN)) |-> ({out_up_re, out_up_im} == $past(up_pk, BLK_LEN)));

    // R3: a sample fed while the select was 1 comes from the lower lane 2L cycles back
    assert_upper_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(sel_w, BLK_LEN)) |-> ({out_up_re, out_up_im} == $past(lo_pk, 2 * BLK_LEN)));

endmodule

// File: tb/lane_shuffler_tb.sv
`timescale 1ns/1ps
module lane_shuffler_tb;

    localparam int DW = 12;
    localparam int LW = 2 * DW;
    localparam int NH = 1024;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, in_valid, in_start;
    logic [DW-1:0] up_re, up_im, lo_re, lo_im;

    logic          ov  [3];
    logic [DW-1:0] our [3], oui [3], olr [3], oli [3];
    logic [LW-1:0] ou  [3], ol  [3];

    for (genvar k = 0; k < 3; k++) begin : g_pack
        assign ou[k] = {our[k], oui[k]};
        assign ol[k] = {olr[k], oli[k]};
    end

    lane_shuffler #(.BLK_LEN(4), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .up_re(up_re), .up_im(up_im), .lo_re(lo_re), .lo_im(lo_im),
        .out_valid(ov[0]), .out_up_re(our[0]), .out_up_im(oui[0]),
        .out_lo_re(olr[0]), .out_lo_im(oli[0]));

    lane_shuffler #(.BLK_LEN(1), .DW(DW)) u_dut_l1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .up_re(up_re), .up_im(up_im), .lo_re(lo_re), .lo_im(lo_im),
        .out_valid(ov[1]), .out_up_re(our[1]), .out_up_im(oui[1]),
        .out_lo_re(olr[1]), .out_lo_im(oli[1]));

    lane_shuffler #(.BLK_LEN(2), .DW(DW)) u_dut_l2 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .up_re(up_re), .up_im(up_im), .lo_re(lo_re), .lo_im(lo_im),
        .out_valid(ov[2]), .out_up_re(our[2]), .out_up_im(oui[2]),
        .out_lo_re(olr[2]), .out_lo_im(oli[2]));

    // Stimulus history (cycle-indexed) for the reference model
    logic [LW-1:0] up_h  [NH];
    logic [LW-1:0] lo_h  [NH];
    bit            vld_h [NH];
    int            pos_h [NH];
    int            cyc, pos, total, bad;
    bit            done;

    function automatic int len_of(input int k);
        return (k == 0) ? 4 : ((k == 1) ? 1 : 2);
    endfunction

    function automatic logic [LW-1:0] h_up(input int c);
        return (c < 0) ? '0 : up_h[c];
    endfunction

    function automatic logic [LW-1:0] h_lo(input int c);
        return (c < 0) ? '0 : lo_h[c];
    endfunction

    // Model select: 0 before any start, else the phase parity of the frame position
    function automatic bit h_sel(input int c, input int len);
        if (c < 0) return 1'b0;
        if (pos_h[c] < 0) return 1'b0;
        return ((pos_h[c] / len) % 2) == 1;
    endfunction

    function automatic logic [LW-1:0] h_mux_up(input int c, input int len);
        if (c < 0) return '0;
        return h_sel(c, len) ? h_lo(c - len) : h_up(c);
    endfunction

    task automatic check(input string tag, input int len, input string what,
                         input logic [LW-1:0] act, input logic [LW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s L=%0d %s cyc=%0d act=%h exp=%h", tag, len, what, cyc, act, exp);
        end
    endtask

    // Drive one input pair, check all outputs mid-cycle, advance to the next cycle
    task automatic step(input string scen, input bit v, input bit s);
        up_re    = cyc[11:0];
        up_im    = 12'hA00 ^ cyc[11:0];
        lo_re    = 12'h400 + cyc[11:0];
        lo_im    = 12'h800 ^ cyc[11:0];
        in_valid = v;
        in_start = s;
        if (s) pos = 0;
        else if (pos >= 0) pos++;
        up_h[cyc]  = {up_re, up_im};
        lo_h[cyc]  = {lo_re, lo_im};
        vld_h[cyc] = v;
        pos_h[cyc] = pos;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            int    len;
            string tag;
            len = len_of(k);
            if (pos < 0)               tag = "R7";
            else if (h_sel(cyc, len))  tag = "R2";
            else                       tag = "R3";
            // R8: real/imag packed as {re, im}; compared as one word
            check({scen, "/", tag, "/R8"}, len, "upper", ou[k], h_mux_up(cyc - len, len));
            check({scen, "/", tag, "/R8"}, len, "lower", ol[k],
                  h_sel(cyc, len) ? h_up(cyc) : h_lo(cyc - len));
            check({scen, "/R4"}, len, "valid", {{(LW-1){1'b0}}, ov[k]},
                  {{(LW-1){1'b0}}, ((cyc - len) < 0) ? 1'b0 : vld_h[cyc - len]});
        end
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++) begin
            check("R1", len_of(k), "valid", {{(LW-1){1'b0}}, ov[k]}, '0);
            check("R1", len_of(k), "upper", ou[k], '0);
            check("R1", len_of(k), "lower", ol[k], '0);
        end
    endtask

    task automatic t_idle();
        // R7: no start yet, both lanes delayed straight through
        for (int i = 0; i < 12; i++) step("R7", 1'b1, 1'b0);
    endtask

    task automatic t_stream();
        // R5: continuous back-to-back frames after one start
        step("R5", 1'b1, 1'b1);
        for (int i = 0; i < 47; i++) step("R5", 1'b1, 1'b0);
    endtask

    task automatic t_restart();
        // R6: restarts landing mid-frame at different offsets
        step("R6", 1'b1, 1'b1);
        for (int i = 0; i < 2; i++) step("R6", 1'b1, 1'b0);
        step("R6", 1'b1, 1'b1);
        for (int i = 0; i < 5; i++) step("R6", 1'b1, 1'b0);
        step("R6", 1'b1, 1'b1);
        for (int i = 0; i < 20; i++) step("R6", 1'b1, 1'b0);
    endtask

    task automatic t_gaps();
        // R4: valid gaps are delayed only and do not disturb the data order
        for (int i = 0; i < 24; i++) step("R4", (i % 3) != 0, 1'b0);
        for (int i = 0; i < 10; i++) step("R4", 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired at cyc=%0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        total    = 0;
        bad      = 0;
        done     = 1'b0;
        cyc      = 0;
        pos      = -1;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_start = 1'b0;
        up_re    = '0;
        up_im    = '0;
        lo_re    = '0;
        lo_im    = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_idle();
        t_stream();
        t_restart();
        t_gaps();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule